// File: doc/BRIEF.md
# Timed Sleep and Power-Down Controller

This block puts a device into one of two low-power states and brings it back. Software writes a 16-bit configuration word through a byte-lane write port. The low byte holds a stay length in whole seconds. Two bits in the high byte request either a light sleep, which keeps volatile settings, or a power-down, which loses them. The request is only armed by the write. It takes effect when the active-low chip select is next released, which is its low-to-high edge.

With a nonzero length, the block counts one-second ticks and returns to the active state by itself when the length has elapsed. A length of zero keeps the device in the low-power state until something wakes it. Three things wake it: a new selection (a falling edge of the chip select), the synchronous active-low reset, or the timeout. When the block leaves power-down through a chip-select falling edge or a timeout, it raises a one-cycle pulse that tells the rest of the chip to drop its volatile state. The stay-length field is wiped by that same pulse.

The one-second tick comes from an internal clock divider. The number of clocks in one second is set by a parameter. Power gating itself is left to the surrounding logic.

Top module: `slpctl_top`

## Requirements
- R1: After a cycle with `rst_n` low, `in_sleep`, `in_pdown` and `vol_clear` are 0, both mode bits are cleared, and the stay length is 0.
- R2: A write with `cfg_be[0]` set loads `cfg_wdata[7:0]` as the stay length in seconds. A write with `cfg_be[1]` set loads `cfg_wdata[8]` (sleep request) and `cfg_wdata[9]` (power-down request). Bits 15:10 have no effect.
- R3: A low-power state is entered only on a rising edge of `cs_n` seen while a request bit is set. The matching output rises in the cycle after the clock edge that samples `cs_n` high. With no request armed, a `cs_n` rising edge leaves both outputs at 0.
- R4: When both request bits are set, the rising edge of `cs_n` enters sleep, not power-down.
- R5: With a nonzero stay length D, the low-power output stays high for exactly D × CLK_PER_SEC clock cycles and then returns to 0 without any other stimulus.
- R6: A stay length of 0 keeps the low-power output high until a wake event.
- R7: A falling edge of `cs_n` wakes the block from sleep or power-down. The output drops in the cycle after the edge is sampled.
- R8: A reset cycle wakes the block from either low-power state and does not raise `vol_clear`.
- R9: Both request bits clear on wake. A later `cs_n` rising edge without a new write does not re-enter a low-power state.
- R10: `vol_clear` is high for exactly one cycle, in the cycle in which `in_pdown` first reads 0 after a power-down ends by timeout or by `cs_n`. Leaving sleep never raises it.
- R11: The stay length survives a sleep period and is cleared to 0 when a power-down period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also a wake event |
| cs_n | input | 1 | Active-low chip select, synchronous to `clk` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte-lane enables: bit 0 for the stay length, bit 1 for the request bits |
| cfg_wdata | input | 16 | Configuration write data |
| in_sleep | output | 1 | High while in sleep |
| in_pdown | output | 1 | High while in power-down |
| vol_clear | output | 1 | One-cycle pulse on leaving power-down |

## Verification
The bench measures the exact length of each timed stay in clock cycles. A divider or countdown that is off by one tick would stretch or shorten it by a whole second's worth of cycles.

The bench also probes these corner cases:
- Both request bits set. A design with the wrong priority would power down instead of sleeping.
- A sleep issued right after a power-down. A design that kept the length across power-down would time out instead of staying indefinitely.
- A chip-select toggle after a wake. A design that did not clear its requests would fall asleep again.
- A reset or a sleep wake. The bench checks that neither raises the volatile-clear pulse, which a design that pulsed on every exit would do.

// File: rtl/slpctl_pkg.sv
// Shared types and field positions for the sleep controller.
// Assumes a 16-bit configuration word with the stay length in the low byte.
package slpctl_pkg;
    localparam int CFG_W     = 16;
    localparam int DUR_W     = 8;
    localparam int SLEEP_BIT = 8;   // sleep request, wins over power-down
    localparam int PDOWN_BIT = 9;   // power-down request

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_SLEEP  = 2'd1,
        PS_PDOWN  = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/slpctl_cfg.sv
// Configuration register: stay length and the two request bits.
// Byte lane 0 writes the length, lane 1 writes the requests.
// A wake clears the requests and a power-down exit wipes the length; both
// clears win over a write in the same cycle. Synchronous active-low reset.
module slpctl_cfg
    import slpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              clr_req,
    input  logic              clr_dur,
    output logic [DUR_W-1:0]  dur,
    output logic              req_sleep,
    output logic              req_pdown
);
    logic [1:0] req_q;

    // Stay-length field: lane-0 writes, wiped after a power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dur <= '0;
        end else if (clr_dur) begin
            dur <= '0;
        end else if (we && be[0]) begin
            dur <= wdata[DUR_W-1:0];
        end
    end

    // Request bits: lane-1 writes, cleared on any wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 2'b00;
        end else if (clr_req) begin
            req_q <= 2'b00;
        end else if (we && be[1]) begin
            req_q <= {wdata[PDOWN_BIT], wdata[SLEEP_BIT]};
        end
    end

    assign req_sleep = req_q[0];
    assign req_pdown = req_q[1];

    AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (req_q == 2'b00)); // R9
    AST_DUR_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dur |=> (dur == '0)); // R11
endmodule

// File: rtl/slpctl_tick.sv
// One-second tick divider. It counts only while run is high, so each
// low-power stay starts on a whole-second boundary. tick is a one-cycle
// pulse on the last clock of each second.
module slpctl_tick #(
    parameter int CLK_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_SEC - 1);

    logic [CW-1:0] div_cnt;

    // Divider counter: restarts whenever the block is not in a stay.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = run && (div_cnt == LAST);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= LAST); // R5
    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_cnt == '0)); // R5
endmodule

// File: rtl/slpctl_fsm.sv
// Power-state sequencer. It detects chip-select edges, enters a stay on a
// release edge (cs_n rising) when a request is armed, and counts the stay
// length down in seconds. It wakes on a select edge (cs_n falling) or on
// timeout, and pulses vol_clear after a power-down. Assumes cs_n is
// already synchronous to clk.
module slpctl_fsm
    import slpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              req_sleep,
    input  logic              req_pdown,
    input  logic [DUR_W-1:0]  dur,
    input  logic              tick,
    output pwr_state_t        state,
    output logic              wake,
    output logic              vol_clear
);
    pwr_state_t       nxt;
    logic             cs_q;
    logic             cs_rise;
    logic             cs_fall;
    logic             timeout;
    logic [DUR_W-1:0] remain;

    // Previous chip-select level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
        end
    end

    assign cs_rise = cs_n && !cs_q;
    assign cs_fall = !cs_n && cs_q;
    assign timeout = tick && (remain == DUR_W'(1));

    // Next-state decode; sleep wins over power-down.
    always_comb begin
        nxt  = state;
        wake = 1'b0;
        case (state)
            PS_ACTIVE: begin
                if (cs_rise && req_sleep) begin
                    nxt = PS_SLEEP;
                end else if (cs_rise && req_pdown) begin
                    nxt = PS_PDOWN;
                end
            end
            PS_SLEEP, PS_PDOWN: begin
                if (cs_fall || timeout) begin
                    nxt  = PS_ACTIVE;
                    wake = 1'b1;
                end
            end
            default: begin
                nxt = PS_ACTIVE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_ACTIVE;
        end else begin
            state <= nxt;
        end
    end

    // Remaining seconds: loaded on entry, zero means no timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (state == PS_ACTIVE) begin
            remain <= (nxt != PS_ACTIVE) ? dur : '0;
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Volatile-clear pulse, one cycle after a power-down ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_clear <= 1'b0;
        end else begin
            vol_clear <= wake && (state == PS_PDOWN);
        end
    end

    AST_NO_STRAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && !cs_rise) |=> (state == PS_ACTIVE)); // R3
    AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ACTIVE && cs_rise && req_sleep) |=> (state == PS_SLEEP)); // R4
    AST_SELECT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_ACTIVE && cs_fall) |=> (state == PS_ACTIVE)); // R7
    AST_INDEFINITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_ACTIVE && remain == '0 && !cs_fall) |=> (state != PS_ACTIVE)); // R6
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vol_clear |=> !vol_clear); // R10
    AST_CLEAR_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
        vol_clear |-> ($past(state) == PS_PDOWN && state == PS_ACTIVE)); // R10
endmodule

// File: rtl/slpctl_top.sv
// Timed sleep and power-down controller top. It ties together the
// configuration register, the one-second divider and the state sequencer.
// Assumes every input is synchronous to clk.
module slpctl_top #(
    parameter int CLK_PER_SEC = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_be,
    input  logic [15:0] cfg_wdata,
    output logic        in_sleep,
    output logic        in_pdown,
    output logic        vol_clear
);
    import slpctl_pkg::*;

    logic [DUR_W-1:0] dur;
    logic             req_sleep;
    logic             req_pdown;
    logic             tick;
    logic             wake;
    pwr_state_t       state;

    slpctl_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .clr_req   (wake),
        .clr_dur   (vol_clear),
        .dur       (dur),
        .req_sleep (req_sleep),
        .req_pdown (req_pdown)
    );

    slpctl_tick #(.CLK_PER_SEC(CLK_PER_SEC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != PS_ACTIVE),
        .tick  (tick)
    );

    slpctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .req_sleep (req_sleep),
        .req_pdown (req_pdown),
        .dur       (dur),
        .tick      (tick),
        .state     (state),
        .wake      (wake),
        .vol_clear (vol_clear)
    );

    assign in_sleep = (state == PS_SLEEP);
    assign in_pdown = (state == PS_PDOWN);

    AST_EXCLUSIVE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_sleep, in_pdown})); // R3
endmodule

// File: tb/test_slpctl_top.sv
// Bench for slpctl_top: a vector table walked by one loop, then directed
// tests for reset and corner cases. Inputs change and outputs are sampled
// on the falling clock edge.
module test_slpctl_top;
    localparam int DIV = 8;
    localparam int NV  = 10;

    // Vector fields: byte enables, write data, expected mode (0 none,
    // 1 sleep, 2 power-down), expected stay in seconds (0 = indefinite).
    localparam logic [27:0] VEC [NV] = '{
        {2'b01, 16'h0003, 2'd0, 8'd0},  // R2 length only
        {2'b10, 16'h0100, 2'd1, 8'd3},  // R5 timed sleep
        {2'b11, 16'h0202, 2'd2, 8'd2},  // R5 timed power-down
        {2'b10, 16'h0100, 2'd1, 8'd0},  // R11 length wiped -> R6
        {2'b11, 16'h0304, 2'd1, 8'd4},  // R4 both set
        {2'b11, 16'h0200, 2'd2, 8'd0},  // R6 indefinite power-down
        {2'b11, 16'hFC05, 2'd0, 8'd0},  // R2 unused bits only
        {2'b10, 16'h0100, 2'd1, 8'd5},  // R11 length kept
        {2'b01, 16'h0301, 2'd0, 8'd0},  // R2 lane 1 disabled
        {2'b10, 16'h0200, 2'd2, 8'd1}   // R10 one-second power-down
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0000;
    logic        in_sleep;
    logic        in_pdown;
    logic        vol_clear;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    slpctl_top #(.CLK_PER_SEC(DIV)) i_slpctl_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cfg_we    (cfg_we),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .in_sleep  (in_sleep),
        .in_pdown  (in_pdown),
        .vol_clear (vol_clear)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 2'b00;
    endtask

    function automatic int mode_now();
        return in_pdown ? 2 : (in_sleep ? 1 : 0);
    endfunction

    // Release chip select and sample one cycle later.
    task automatic release_cs();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int len;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sleep after reset", in_sleep, 0);
        check("R1 pdown after reset", in_pdown, 0);
        check("R1 clear after reset", vol_clear, 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  be;
            logic [15:0] d;
            int          em;
            int          el;
            be = VEC[v][27:26];
            d  = VEC[v][25:10];
            em = int'(VEC[v][9:8]);
            el = int'(VEC[v][7:0]);
            @(negedge clk);
            cs_n = 1'b0;
            wr(be, d);
            release_cs();
            check($sformatf("R3 entry mode v%0d", v), mode_now(), em);
            if (em == 0) begin
                repeat (DIV) @(negedge clk);
                check($sformatf("R2 no entry v%0d", v), mode_now(), 0);
            end else if (el > 0) begin
                len = 0;
                pulses = 0;
                while (mode_now() == em && len < 300 * DIV) begin
                    len++;
                    @(negedge clk);
                end
                check($sformatf("R5 stay cycles v%0d", v), len, el * DIV);
                check($sformatf("R10 clear on exit v%0d", v), vol_clear, (em == 2) ? 1 : 0);
                @(negedge clk);
                check($sformatf("R10 clear one cycle v%0d", v), vol_clear, 0);
            end else begin
                repeat (6 * DIV) @(negedge clk);
                check($sformatf("R6 still low-power v%0d", v), mode_now(), em);
                cs_n = 1'b0;
                @(negedge clk);
                check($sformatf("R7 select wakes v%0d", v), mode_now(), 0);
                check($sformatf("R10 clear on select v%0d", v), vol_clear, (em == 2) ? 1 : 0);
            end
        end

        // R9: no re-entry after wake without a new write.
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        release_cs();
        repeat (2) @(negedge clk);
        check("R9 no re-entry", mode_now(), 0);

        // R7: early wake from a timed sleep, no clear pulse.
        cs_n = 1'b0;
        wr(2'b11, 16'h0132);
        release_cs();
        check("R7 timed sleep entered", mode_now(), 1);
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R7 early wake", mode_now(), 0);
        check("R10 no clear after sleep", vol_clear, 0);

        // R8: reset wakes from power-down without a clear pulse.
        wr(2'b10, 16'h0200);
        release_cs();
        check("R8 pdown entered", mode_now(), 2);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset wakes", mode_now(), 0);
        check("R8 no clear on reset", vol_clear, 0);
        rst_n = 1'b1;
        cs_n = 1'b0;
        @(negedge clk);
        check("R8 clear stays low", vol_clear, 0);
        release_cs();
        check("R1 requests cleared by reset", mode_now(), 0);

        // R1: length reset to zero, so a bare sleep request is indefinite.
        @(negedge clk);
        cs_n = 1'b0;
        wr(2'b10, 16'h0100);
        release_cs();
        repeat (60 * DIV) @(negedge clk);
        check("R1 length zero after reset", mode_now(), 1);
        cs_n = 1'b0;
        @(negedge clk);
        check("R7 select wakes sleep", mode_now(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule